// File: doc/BRIEF.md
# Secure Bit-Alias Register Bank

This block holds a small bank of 32-bit always-on control registers behind a memory-mapped slave port that two masters share. Each master drives a request with a valid/ready handshake, a 16-bit byte address, a write flag, 32-bit write data and a flag that marks it as a secure master. The granted master gets read data and an error flag back in the same cycle.

Bits 13:0 of the address give the byte offset of a register. Registers sit on a 4-byte stride, so the register index is bits 13:2. Bits 15:14 choose the kind of access. A plain write replaces the whole word. The two alias forms force a single bit to 1 or to 0, and their write data carries a bit number, not a mask. A master can therefore change one bit without a software read-modify-write, even when another master uses the same register. Any master may read, but only a secure master may write. When both masters request in the same cycle, master 0 is served first. Every update completes in a single clock edge, so interleaved single-bit updates from the two masters are never lost.

Top module: `aon_bitalias_bank`

## Requirements
- R1: Reset, synchronous and active high, sets every register to zero.
- R2: A granted secure write with address bits 15:14 = 00 replaces the whole addressed word with the write data. The register index is address bits 13:2, and address bits 1:0 are ignored.
- R3: A granted secure write with address bits 15:14 = 11 sets to 1 the bit whose number is write data bits 4:0. All other bits keep their value.
- R4: A granted secure write with address bits 15:14 = 10 clears to 0 the bit whose number is write data bits 4:0. All other bits keep their value.
- R5: In an alias write (bits 15:14 = 1x), write data bits 31:5 have no effect on the result.
- R6: A write from a master whose secure flag is 0 returns error = 1 and leaves every register unchanged.
- R7: A read from any master, secure or not, returns error = 0 and the current register word. A read with bits 15:14 = 1x behaves as a plain read and changes nothing.
- R8: Address bits 15:14 = 01 are reserved. Any access with that code, read or write, returns error = 1 and read data 0, and changes nothing.
- R9: An access whose register index is at or above the number of implemented registers returns error = 1 and read data 0, and changes nothing.
- R10: Priority is fixed, with master 0 first. A master's ready is high exactly when it is the granted requester. A master that is not granted sees read data 0 and error 0.
- R11: Single-bit alias writes from both masters on back-to-back cycles all take effect, and none is lost.
- R12: The response comes in the same cycle as ready and reflects the register value before that cycle's update. An update is visible to the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m0_valid | input | 1 | Master 0 request valid |
| m0_ready | output | 1 | Master 0 request accepted this cycle |
| m0_addr | input | 16 | Master 0 byte address with alias code in bits 15:14 |
| m0_write | input | 1 | Master 0 write (1) or read (0) |
| m0_wdata | input | 32 | Master 0 write data or bit number |
| m0_secure | input | 1 | Master 0 is a secure master |
| m0_rdata | output | 32 | Master 0 read data |
| m0_err | output | 1 | Master 0 error response |
| m1_valid | input | 1 | Master 1 request valid |
| m1_ready | output | 1 | Master 1 request accepted this cycle |
| m1_addr | input | 16 | Master 1 byte address with alias code in bits 15:14 |
| m1_write | input | 1 | Master 1 write (1) or read (0) |
| m1_wdata | input | 32 | Master 1 write data or bit number |
| m1_secure | input | 1 | Master 1 is a secure master |
| m1_rdata | output | 32 | Master 1 read data |
| m1_err | output | 1 | Master 1 error response |

## Verification
The bench targets several corner cases:
- Bit numbers 0 and 31, and alias writes whose upper data bits are all ones. A decoder that used the whole data word as a mask or a shift amount would corrupt other bits.
- Non-secure writes in both plain and alias form, the reserved alias code and register indices just past the end of the bank. A design that only flags these would still modify a register, and the next read would expose it.
- Both masters issuing single-bit writes to the same register in the same cycle and on following cycles. A merged or dropped grant would lose one of the updates.
- A read in the same cycle as an update, which must return the old word.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 16;
    localparam int OFF_W   = 14;
    localparam int WIDX_W  = OFF_W - 2;
    localparam int BIT_W   = $clog2(DATA_W);

    typedef enum logic [1:0] {
        OP_PLAIN = 2'b00,
        OP_RSVD  = 2'b01,
        OP_CLR   = 2'b10,
        OP_SET   = 2'b11
    } alias_op_e;

    typedef struct packed {
        logic              write;
        logic              secure;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bank_req_t;

    function automatic logic [DATA_W-1:0] apply_op(alias_op_e op,
                                                   logic [DATA_W-1:0] old_word,
                                                   logic [DATA_W-1:0] wdata);
        logic [DATA_W-1:0] onehot;
        onehot = {{(DATA_W-1){1'b0}}, 1'b1} << wdata[BIT_W-1:0];
        case (op)
            OP_SET:  return old_word | onehot;
            OP_CLR:  return old_word & ~onehot;
            default: return wdata;
        endcase
    endfunction

endpackage

// File: rtl/bank_arbiter.sv
module bank_arbiter #(
    parameter int NM = 2
) (
    input  logic [NM-1:0] req,
    output logic [NM-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < NM; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import bank_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  bank_req_t         req,
    input  logic              req_vld,
    input  logic [DATA_W-1:0] cur_word,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              err,
    output logic              upd_en,
    output logic [DATA_W-1:0] upd_val,
    output logic [DATA_W-1:0] rsp_data
);
    logic [WIDX_W-1:0] word_idx;
    logic              in_range;
    alias_op_e         op;

    assign word_idx = req.addr[OFF_W-1:2];
    assign in_range = {1'b0, word_idx} < (WIDX_W+1)'(NUM_REGS);
    assign op       = alias_op_e'(req.addr[ADDR_W-1:ADDR_W-2]);
    assign rd_idx   = word_idx[IDX_W-1:0];

    assign err      = req_vld && ((op == OP_RSVD) || !in_range ||
                                  (req.write && !req.secure));
    assign upd_en   = req_vld && req.write && !err;
    assign upd_val  = apply_op(op, cur_word, req.wdata);
    assign rsp_data = (req_vld && !err) ? cur_word : '0;
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import bank_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         upd_en,
    input  logic [IDX_W-1:0]             upd_idx,
    input  logic [DATA_W-1:0]            upd_val,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [DATA_W-1:0]            rd_word,
    output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (upd_en && (upd_idx == IDX_W'(g))) begin
                regs[g] <= upd_val;
            end
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    assign rd_word = regs[rd_idx];
endmodule

// File: rtl/aon_bitalias_bank.sv
module aon_bitalias_bank
    import bank_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        m0_valid,
    output logic        m0_ready,
    input  logic [15:0] m0_addr,
    input  logic        m0_write,
    input  logic [31:0] m0_wdata,
    input  logic        m0_secure,
    output logic [31:0] m0_rdata,
    output logic        m0_err,
    input  logic        m1_valid,
    output logic        m1_ready,
    input  logic [15:0] m1_addr,
    input  logic        m1_write,
    input  logic [31:0] m1_wdata,
    input  logic        m1_secure,
    output logic [31:0] m1_rdata,
    output logic        m1_err
);
    localparam int NM    = 2;
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    bank_req_t         reqs [NM];
    logic [NM-1:0]     vld;
    logic [NM-1:0]     gnt;
    bank_req_t         sel_req;
    logic              sel_vld;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] cur_word;
    logic              err;
    logic              upd_en;
    logic [DATA_W-1:0] upd_val;
    logic [DATA_W-1:0] rsp_data;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    assign reqs[0] = '{write: m0_write, secure: m0_secure, addr: m0_addr, wdata: m0_wdata};
    assign reqs[1] = '{write: m1_write, secure: m1_secure, addr: m1_addr, wdata: m1_wdata};
    assign vld     = {m1_valid, m0_valid};

    bank_arbiter #(.NM(NM)) u_arb (.req(vld), .gnt(gnt));

    always_comb begin
        sel_req = '0;
        for (int i = 0; i < NM; i++) begin
            if (gnt[i]) sel_req = reqs[i];
        end
    end
    assign sel_vld = |gnt;

    bank_decoder #(.NUM_REGS(NUM_REGS)) u_dec (
        .req      (sel_req),
        .req_vld  (sel_vld),
        .cur_word (cur_word),
        .rd_idx   (rd_idx),
        .err      (err),
        .upd_en   (upd_en),
        .upd_val  (upd_val),
        .rsp_data (rsp_data)
    );

    bank_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (upd_en),
        .upd_idx   (rd_idx),
        .upd_val   (upd_val),
        .rd_idx    (rd_idx),
        .rd_word   (cur_word),
        .regs_flat (regs_flat)
    );

    assign m0_ready = gnt[0];
    assign m1_ready = gnt[1];
    assign m0_err   = gnt[0] & err;
    assign m1_err   = gnt[1] & err;
    assign m0_rdata = gnt[0] ? rsp_data : '0;
    assign m1_rdata = gnt[1] ? rsp_data : '0;
endmodule

// File: rtl/bank_checker.sv
module bank_checker #(
    parameter int NUM_REGS = 16,
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       m0_valid,
    input logic                       m0_ready,
    input logic [15:0]                m0_addr,
    input logic                       m0_write,
    input logic [31:0]                m0_wdata,
    input logic                       m0_secure,
    input logic                       m0_err,
    input logic                       m1_valid,
    input logic                       m1_ready,
    input logic                       m1_err,
    input logic                       upd_en,
    input logic [NUM_REGS*32-1:0]     regs_flat
);
    logic [IDX_W+4:0] bitpos0;
    assign bitpos0 = {m0_addr[IDX_W+1:2], m0_wdata[4:0]};

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (regs_flat == '0));

    assert_m0_first_R10: assert property (@(posedge clk) disable iff (rst)
        m0_valid |-> m0_ready);

    assert_m1_yields_R10: assert property (@(posedge clk) disable iff (rst)
        m1_ready |-> (m1_valid && !m0_valid));

    assert_one_grant_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({m0_ready, m1_ready}));

    assert_nonsecure_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (m0_ready && m0_write && !m0_secure) |-> (m0_err && !upd_en));

    assert_reserved_err_R8: assert property (@(posedge clk) disable iff (rst)
        (m0_ready && m0_addr[15:14] == 2'b01) |-> m0_err);

    assert_error_no_side_effect_R9: assert property (@(posedge clk) disable iff (rst)
        ((m0_ready && m0_err) || (m1_ready && m1_err)) |=> $stable(regs_flat));

    assert_set_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_en && m0_ready && m0_addr[15:14] == 2'b11) |=> regs_flat[$past(bitpos0)]);

    assert_clear_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && m0_ready && m0_addr[15:14] == 2'b10) |=> !regs_flat[$past(bitpos0)]);

    assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(regs_flat));
endmodule

bind aon_bitalias_bank bank_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .m0_valid  (m0_valid),
    .m0_ready  (m0_ready),
    .m0_addr   (m0_addr),
    .m0_write  (m0_write),
    .m0_wdata  (m0_wdata),
    .m0_secure (m0_secure),
    .m0_err    (m0_err),
    .m1_valid  (m1_valid),
    .m1_ready  (m1_ready),
    .m1_err    (m1_err),
    .upd_en    (upd_en),
    .regs_flat (regs_flat)
);

// File: tb/test_aon_bitalias_bank.sv
module test_aon_bitalias_bank;
    localparam int NREGS = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m0_valid = 0, m0_write = 0, m0_secure = 0;
    logic [15:0] m0_addr = '0;
    logic [31:0] m0_wdata = '0;
    logic        m1_valid = 0, m1_write = 0, m1_secure = 0;
    logic [15:0] m1_addr = '0;
    logic [31:0] m1_wdata = '0;
    logic        m0_ready, m0_err, m1_ready, m1_err;
    logic [31:0] m0_rdata, m1_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] model [NREGS];

    always #2 clk = ~clk;

    aon_bitalias_bank #(.NUM_REGS(NREGS)) i_aon_bitalias_bank (
        .clk(clk), .rst(rst),
        .m0_valid(m0_valid), .m0_ready(m0_ready), .m0_addr(m0_addr),
        .m0_write(m0_write), .m0_wdata(m0_wdata), .m0_secure(m0_secure),
        .m0_rdata(m0_rdata), .m0_err(m0_err),
        .m1_valid(m1_valid), .m1_ready(m1_ready), .m1_addr(m1_addr),
        .m1_write(m1_write), .m1_wdata(m1_wdata), .m1_secure(m1_secure),
        .m1_rdata(m1_rdata), .m1_err(m1_err)
    );

    function automatic logic [15:0] ad(logic [1:0] op, int idx, logic [1:0] lo = 2'b00);
        return {op, 12'(idx), lo};
    endfunction

    function automatic void expect_rsp(input bit g, input logic [15:0] a, input bit w,
                                       input bit s, output bit e, output logic [31:0] rd);
        int idx;
        idx = int'(a[13:2]);
        e   = g && (a[15:14] == 2'b01 || idx >= NREGS || (w && !s));
        rd  = (g && !e) ? model[idx] : 32'h0;
    endfunction

    function automatic void model_update(input logic [15:0] a, input logic [31:0] d);
        int idx;
        idx = int'(a[13:2]);
        case (a[15:14])
            2'b11:   model[idx][d[4:0]] = 1'b1;
            2'b10:   model[idx][d[4:0]] = 1'b0;
            default: model[idx] = d;
        endcase
    endfunction

    task automatic cmp(string tag, string who, bit r, bit e, logic [31:0] rd,
                       bit xr, bit xe, logic [31:0] xrd);
        checks++;
        if (r !== xr || e !== xe || rd !== xrd) begin
            fails++;
            $display("FAIL %s %s: ready=%0b err=%0b rdata=%h expected ready=%0b err=%0b rdata=%h",
                     tag, who, r, e, rd, xr, xe, xrd);
        end
    endtask

    task automatic step(string tag,
                        bit v0, logic [15:0] a0, bit w0, logic [31:0] d0, bit s0,
                        bit v1 = 0, logic [15:0] a1 = '0, bit w1 = 0,
                        logic [31:0] d1 = '0, bit s1 = 0);
        bit g0, g1, e0, e1;
        logic [31:0] r0, r1;
        @(negedge clk);
        m0_valid = v0; m0_addr = a0; m0_write = w0; m0_wdata = d0; m0_secure = s0;
        m1_valid = v1; m1_addr = a1; m1_write = w1; m1_wdata = d1; m1_secure = s1;
        #1;
        g0 = v0;
        g1 = v1 && !v0;
        expect_rsp(g0, a0, w0, s0, e0, r0);
        expect_rsp(g1, a1, w1, s1, e1, r1);
        cmp(tag, "m0", m0_ready, m0_err, m0_rdata, g0, e0, r0);
        cmp(tag, "m1", m1_ready, m1_err, m1_rdata, g1, e1, r1);
        if (g0 && w0 && !e0) model_update(a0, d0);
        if (g1 && w1 && !e1) model_update(a1, d1);
    endtask

    task automatic idle();
        step("R10", 0, '0, 0, '0, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 / R7: all registers zero after reset, non-secure reads from both masters
        for (int i = 0; i < NREGS; i++) step("R1", 1, ad(2'b00, i), 0, '0, 0);
        for (int i = 0; i < NREGS; i++) step("R7", 0, '0, 0, '0, 0, 1, ad(2'b00, i), 0, '0, 0);

        // R2: plain secure writes, low address bits ignored
        step("R2", 1, ad(2'b00, 0), 1, 32'hDEAD_BEEF, 1);
        step("R2", 1, ad(2'b00, 5, 2'b11), 1, 32'h1234_5678, 1);
        step("R2", 1, ad(2'b00, 15), 1, 32'hA5A5_0F0F, 1);
        step("R12", 1, ad(2'b00, 5), 0, '0, 0);
        step("R2", 0, '0, 0, '0, 0, 1, ad(2'b00, 5, 2'b01), 1, 32'h0000_00FF, 1);
        step("R12", 1, ad(2'b00, 5), 0, '0, 1);

        // R3: set bits at boundaries
        step("R3", 1, ad(2'b11, 3), 1, 32'd0, 1);
        step("R3", 1, ad(2'b11, 3), 1, 32'd31, 1);
        step("R3", 1, ad(2'b11, 3), 1, 32'd7, 1);
        step("R3", 1, ad(2'b11, 15), 1, 32'd4, 1);
        step("R3", 1, ad(2'b00, 3), 0, '0, 0);

        // R4: clear bits
        step("R4", 1, ad(2'b10, 0), 1, 32'd0, 1);
        step("R4", 1, ad(2'b10, 0), 1, 32'd31, 1);
        step("R4", 1, ad(2'b10, 3), 1, 32'd7, 1);
        step("R4", 1, ad(2'b00, 0), 0, '0, 0);

        // R5: upper data bits ignored in alias writes
        step("R5", 1, ad(2'b11, 7), 1, 32'hFFFF_FFE9, 1);
        step("R5", 1, ad(2'b10, 15), 1, 32'hFFFF_FFE0, 1);
        step("R5", 1, ad(2'b00, 7), 0, '0, 0);
        step("R5", 1, ad(2'b00, 15), 0, '0, 0);

        // R6: non-secure writes rejected in every form
        step("R6", 1, ad(2'b00, 0), 1, 32'h0, 0);
        step("R6", 1, ad(2'b11, 7), 1, 32'd1, 0);
        step("R6", 0, '0, 0, '0, 0, 1, ad(2'b10, 7), 1, 32'd9, 0);
        step("R6", 1, ad(2'b00, 0), 0, '0, 0);
        step("R6", 1, ad(2'b00, 7), 0, '0, 0);

        // R7: reads with alias codes change nothing
        step("R7", 1, ad(2'b11, 3), 0, 32'd2, 0);
        step("R7", 0, '0, 0, '0, 0, 1, ad(2'b10, 3), 0, 32'd31, 1);
        step("R7", 1, ad(2'b00, 3), 0, '0, 0);

        // R8: reserved code
        step("R8", 1, ad(2'b01, 3), 1, 32'hFFFF_FFFF, 1);
        step("R8", 1, ad(2'b01, 3), 0, '0, 1);
        step("R8", 1, ad(2'b00, 3), 0, '0, 0);

        // R9: out-of-range register index
        step("R9", 1, ad(2'b00, NREGS), 1, 32'h5555_5555, 1);
        step("R9", 1, ad(2'b11, 4095), 1, 32'd3, 1);
        step("R9", 0, '0, 0, '0, 0, 1, ad(2'b00, NREGS), 0, '0, 1);
        step("R9", 1, ad(2'b00, 0), 0, '0, 0);

        // R10 / R11: contention; master 1 waits, then gets served
        step("R10", 1, ad(2'b11, 9), 1, 32'd1, 1, 1, ad(2'b11, 9), 1, 32'd2, 1);
        step("R11", 0, '0, 0, '0, 0, 1, ad(2'b11, 9), 1, 32'd2, 1);
        step("R11", 1, ad(2'b11, 9), 1, 32'd30, 1, 1, ad(2'b10, 9), 1, 32'd1, 1);
        step("R11", 0, '0, 0, '0, 0, 1, ad(2'b10, 9), 1, 32'd1, 1);
        step("R11", 1, ad(2'b00, 9), 0, '0, 0);
        idle();

        // R11 / R12: back-to-back alternating updates on one register
        for (int b = 0; b < 32; b++) begin
            if (b % 2 == 0) step("R11", 1, ad(2'b11, 12), 1, 32'(b), 1);
            else            step("R11", 0, '0, 0, '0, 0, 1, ad(2'b11, 12), 1, 32'(b), 1);
        end
        for (int b = 0; b < 32; b += 3) step("R12", 1, ad(2'b10, 12), 1, 32'(b), 1);

        // R12: final read-back of the whole bank
        for (int i = 0; i < NREGS; i++) step("R12", 0, '0, 0, '0, 0, 1, ad(2'b00, i), 0, '0, 0);
        idle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule